// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps a 64Mb SDRAM's contents alive on behalf of a main memory controller. A free-running interval counter produces one refresh obligation every 15.625 µs worth of clock cycles. Obligations collect in a small saturating backlog counter. While the backlog is non-zero the block asks the main controller for the command bus. Once the bus is granted, it closes every bank with a precharge-all, waits the row-precharge time, issues one AUTO REFRESH and then waits the refresh cycle time. After that it hands the bus back. When the backlog reaches eight, an urgent flag tells the main controller that refresh is being starved.

A level power-down request moves the device into self-refresh through the same bus handshake. The block precharges all banks, waits the precharge time, and issues the refresh command encoding with clock-enable pulled low in the same cycle. Clock-enable then stays low for at least the active-row time. It goes high again only after the request is withdrawn and the system reports a stable clock. A run of NOPs follows to cover the self-refresh exit time. Leaving self-refresh clears the backlog and restarts the interval counter from zero.

Commands appear on active-low chip-select, row strobe, column strobe and write-enable, written {CS#,RAS#,CAS#,WE#}: NOP = 0111, PRECHARGE = 0010, REFRESH = 0001. Address bit 10 is driven high only with PRECHARGE, which selects all banks.

Top module: `sdr_refresh_seq`

## Requirements
- R1: During and directly after reset the block drives NOP (0111) with clock-enable high, and the request, busy and urgent outputs are all low.
- R2: The interval is INTERVAL = CLK_MHZ*15625/1000 cycles. When grants arrive within three cycles, consecutive REFRESH commands are never more than INTERVAL+4 cycles apart.
- R3: After a grant the block issues PRECHARGE (0010) with address bit 10 high. It issues REFRESH (0001) exactly TRP cycles later, with NOPs in between.
- R4: Busy is high on the REFRESH cycle and on the TRC-1 cycles after it, and only NOP is driven in those cycles. Busy is low TRC cycles after the REFRESH.
- R5: A command other than NOP appears only while the grant input is high. Without a grant the request stays raised and the bus carries NOP.
- R6: Missed intervals add to a backlog that saturates at 15. Each REFRESH removes one. Urgent is high exactly while the backlog is 8 or more.
- R7: Self-refresh entry is PRECHARGE, then TRP cycles later the REFRESH encoding (0001) in the same cycle that clock-enable falls.
- R8: Clock-enable rises no sooner than TRAS+1 cycles after the entry cycle, even if the power-down request is withdrawn at once.
- R9: Clock-enable rises only at a clock edge where the power-down request was low and the clock-stable input was high.
- R10: From the cycle clock-enable rises, NOP is driven with busy high for max(TXSR,2) cycles. Busy falls in the cycle after that.
- R11: After self-refresh exit the backlog is empty and the interval restarts. The next refresh request rises exactly INTERVAL+1 cycles after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| clk_stable | input | 1 | High when the clock meets its timing again; gates exit |
| ref_grant | input | 1 | Bus grant from the main controller, held while busy |
| ref_req | output | 1 | Bus request |
| busy | output | 1 | Block owns the bus and a sequence is in progress |
| urgent | output | 1 | Refresh backlog has reached the urgent level |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
The assertions assume that the main controller, once it grants the bus, keeps the grant high for as long as busy is high. They also assume that TRP, TRC and TRAS are at least two cycles. The bench's grant model raises the grant after a random delay of zero to three cycles, holds it through busy, and drops it only when the block is idle. The bench changes the power-down and clock-stable inputs only at falling edges and holds the grant through the whole of each self-refresh stay, so the bus-ownership property always sees a valid grant.

// File: rtl/sdr_refresh_pkg.sv
// Shared encodings and sequencer states for the SDRAM refresh block.
// Assumes command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_refresh_pkg;
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PALL,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RC,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_PARK,
        ST_SR_EXIT
    } seq_state_e;
endpackage

// File: rtl/sdr_wait_timer.sv
// Down-counting wait timer shared by all sequence phases.
// Assumes: a load has priority; 'last' is high when at most one cycle remains.
module sdr_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Load a new wait length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/sdr_ref_pacer.sv
// Refresh pacing: an interval counter produces one obligation per interval,
// obligations collect in a saturating backlog, and each refresh retires one.
// Assumes: 'clr' is held while the device is in self-refresh or leaving it.
module sdr_ref_pacer #(
    parameter int INTERVAL   = 1562,
    parameter int PEND_W     = 4,
    parameter int URGENT_LVL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dec,
    output logic pending,
    output logic urgent
);
    localparam int IW = $clog2(INTERVAL + 1);
    localparam logic [IW-1:0]     LAST_TICK = IW'(INTERVAL - 1);
    localparam logic [PEND_W-1:0] PMAX      = '1;
    localparam logic [PEND_W-1:0] URG_V     = PEND_W'(URGENT_LVL);

    logic [IW-1:0]     ivl_q;
    logic [PEND_W-1:0] pend_q;
    logic              tick;

    assign tick = (ivl_q == LAST_TICK);

    // Interval counter; restarts from zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ivl_q <= '0;
        else if (tick)
            ivl_q <= '0;
        else
            ivl_q <= ivl_q + 1'b1;
    end

    // Backlog: add on tick (saturating), retire on refresh, both cancel.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend_q <= '0;
        else if (tick && !dec && pend_q != PMAX)
            pend_q <= pend_q + 1'b1;
        else if (dec && !tick && pend_q != '0)
            pend_q <= pend_q - 1'b1;
    end

    assign pending = (pend_q != '0);
    assign urgent  = (pend_q >= URG_V);

    // R6: the backlog holds at its ceiling instead of wrapping.
    p_backlog_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) == PMAX && !$past(clr) && !$past(dec)) |-> pend_q == PMAX);
    // R6: urgent can only switch on after an interval has elapsed.
    p_urgent_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent) |-> $past(tick));
endmodule

// File: rtl/sdr_ref_fsm.sv
// Sequencer FSM: bus handshake, precharge-all / refresh, and self-refresh
// entry, residence and exit. Command pins decode from the state register.
// Assumes: grant is held high by the controller for as long as busy is high.
module sdr_ref_fsm
    import sdr_refresh_pkg::*;
#(
    parameter int TRP     = 3,
    parameter int TRC     = 7,
    parameter int TRAS    = 6,
    parameter int XSR_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       sr_req,
    input  logic       clk_stable,
    input  logic       ref_grant,
    output logic       ref_req,
    output logic       busy,
    output logic       ref_done,
    output logic       sr_clr,
    output logic       cke,
    output logic [3:0] cmd,
    output logic       a10
);
    localparam int M1 = (TRP > TRC) ? TRP : TRC;
    localparam int M2 = (TRAS > XSR_CYC) ? TRAS : XSR_CYC;
    localparam int MX = (M1 > M2) ? M1 : M2;
    localparam int WW = $clog2(MX + 1);
    localparam logic [WW-1:0] LD_RP  = WW'(TRP - 1);
    localparam logic [WW-1:0] LD_RC  = WW'(TRC - 1);
    localparam logic [WW-1:0] LD_RAS = WW'(TRAS - 1);
    localparam logic [WW-1:0] LD_XSR = WW'(XSR_CYC);

    seq_state_e    state_q, state_d;
    logic          to_sr_q, to_sr_d;
    logic          ld;
    logic [WW-1:0] ld_val;
    logic          w_last;

    sdr_wait_timer #(.W(WW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .last(w_last)
    );

    // Next-state and timer-load selection.
    always_comb begin
        state_d = state_q;
        to_sr_d = to_sr_q;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_req) begin
                    state_d = ST_REQ;
                    to_sr_d = 1'b1;
                end else if (pending) begin
                    state_d = ST_REQ;
                    to_sr_d = 1'b0;
                end
            end
            ST_REQ:      if (ref_grant) state_d = ST_PALL;
            ST_PALL:     begin state_d = ST_WAIT_RP; ld = 1'b1; ld_val = LD_RP; end
            ST_WAIT_RP:  if (w_last) state_d = to_sr_q ? ST_SR_ENTER : ST_REF;
            ST_REF:      begin state_d = ST_WAIT_RC; ld = 1'b1; ld_val = LD_RC; end
            ST_WAIT_RC:  if (w_last) state_d = ST_IDLE;
            ST_SR_ENTER: begin state_d = ST_SR_HOLD; ld = 1'b1; ld_val = LD_RAS; end
            ST_SR_HOLD:  if (w_last) state_d = ST_SR_PARK;
            ST_SR_PARK: begin
                if (!sr_req && clk_stable) begin
                    state_d = ST_SR_EXIT;
                    ld      = 1'b1;
                    ld_val  = LD_XSR;
                end
            end
            ST_SR_EXIT:  if (w_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            to_sr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            to_sr_q <= to_sr_d;
        end
    end

    // Pin decode from the registered state.
    always_comb begin
        cmd = CMD_NOP;
        a10 = 1'b0;
        cke = 1'b1;
        unique case (state_q)
            ST_PALL:     begin cmd = CMD_PALL; a10 = 1'b1; end
            ST_REF:      cmd = CMD_REF;
            ST_SR_ENTER: begin cmd = CMD_REF; cke = 1'b0; end
            ST_SR_HOLD,
            ST_SR_PARK:  cke = 1'b0;
            default:     ;
        endcase
    end

    assign ref_req  = (state_q == ST_REQ);
    assign busy     = (state_q != ST_IDLE) && (state_q != ST_REQ);
    assign ref_done = (state_q == ST_REF);
    assign sr_clr   = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD) ||
                      (state_q == ST_SR_PARK)  || (state_q == ST_SR_EXIT);

    // R5: a precharge is only started from a granted request.
    p_start_on_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PALL) |-> ($past(ref_grant) && $past(ref_req)));
endmodule

// File: rtl/sdr_refresh_seq.sv
// Top: SDRAM refresh and self-refresh sequencer. Ties pacing to the FSM and
// drives the command pins. Timing parameters are in clock cycles.
// Assumes: TRP, TRC, TRAS >= 2; grant held by the controller while busy.
module sdr_refresh_seq #(
    parameter int CLK_MHZ    = 100,
    parameter int TRP        = 3,
    parameter int TRC        = 7,
    parameter int TRAS       = 6,
    parameter int TXSR       = 8,
    parameter int PEND_W     = 4,
    parameter int URGENT_LVL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic clk_stable,
    input  logic ref_grant,
    output logic ref_req,
    output logic busy,
    output logic urgent,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10
);
    import sdr_refresh_pkg::*;

    localparam int INTERVAL = (CLK_MHZ * 15625) / 1000;
    localparam int XSR_CYC  = (TXSR < 2) ? 2 : TXSR;

    logic       pending, ref_done, sr_clr;
    logic [3:0] cmd;

    sdr_ref_pacer #(
        .INTERVAL(INTERVAL), .PEND_W(PEND_W), .URGENT_LVL(URGENT_LVL)
    ) u_pacer (
        .clk(clk), .rst_n(rst_n), .clr(sr_clr), .dec(ref_done),
        .pending(pending), .urgent(urgent)
    );

    sdr_ref_fsm #(
        .TRP(TRP), .TRC(TRC), .TRAS(TRAS), .XSR_CYC(XSR_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pending(pending), .sr_req(sr_req),
        .clk_stable(clk_stable), .ref_grant(ref_grant), .ref_req(ref_req),
        .busy(busy), .ref_done(ref_done), .sr_clr(sr_clr), .cke(cke),
        .cmd(cmd), .a10(a10)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // ---------------- timing checkers (pin level) ----------------
    localparam logic [15:0] SAT = '1;
    logic [15:0] since_pall_q, low_run_q, high_run_q;

    // Cycles since the last precharge command.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_pall_q <= SAT;
        else if (cmd == CMD_PALL)   since_pall_q <= 16'd1;
        else if (since_pall_q != SAT) since_pall_q <= since_pall_q + 1'b1;
    end

    // Length of the current clock-enable low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || cke)        low_run_q <= '0;
        else if (low_run_q != SAT) low_run_q <= low_run_q + 1'b1;
    end

    // Cycles since clock-enable last rose (saturated out of reset).
    always_ff @(posedge clk) begin
        if (!rst_n)                 high_run_q <= SAT;
        else if (!cke)              high_run_q <= '0;
        else if (high_run_q != SAT) high_run_q <= high_run_q + 1'b1;
    end

    // R3: refresh never follows precharge by less than TRP.
    p_ref_after_rp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (since_pall_q >= 16'(TRP)));
    // R5: any non-NOP command needs the bus grant.
    p_bus_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> ref_grant);
    // R7: clock-enable falls only together with the refresh encoding.
    p_sr_entry_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == CMD_REF));
    // R8: minimum residence in self-refresh.
    p_sr_min_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_run_q >= 16'(TRAS + 1)));
    // R9: exit only on a stable clock with the request withdrawn.
    p_exit_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ($past(clk_stable) && !$past(sr_req)));
    // R10: only NOPs during the exit window, with busy held.
    p_xsr_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && high_run_q < 16'(XSR_CYC)) |-> (cmd == CMD_NOP && busy));
endmodule

// File: tb/sdr_refresh_seq_tb_top.sv
// Bench for the refresh sequencer: random grant latency from a seeded
// $urandom, random self-refresh stays, and directed corner cases.
module sdr_refresh_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ  = 8;
    localparam int TRP      = 3;
    localparam int TRC      = 7;
    localparam int TRAS     = 6;
    localparam int TXSR     = 1;
    localparam int INTERVAL = (CLK_MHZ * 15625) / 1000;
    localparam int URG      = 8;
    localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, REF = 4'b0001;

    logic clk, rst_n, sr_req, clk_stable, ref_grant;
    logic ref_req, busy, urgent, cke, cs_n, ras_n, cas_n, we_n, a10;

    sdr_refresh_seq #(
        .CLK_MHZ(CLK_MHZ), .TRP(TRP), .TRC(TRC), .TRAS(TRAS), .TXSR(TXSR),
        .PEND_W(4), .URGENT_LVL(URG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .clk_stable(clk_stable),
        .ref_grant(ref_grant), .ref_req(ref_req), .busy(busy), .urgent(urgent),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, n_ref = 0;
    int t_pall = -1000, t_ref = -1, last_ref = -1, t_sre = -1, t_x = -1, t_idle = -1;
    bit gap_en = 0, grant_en = 0, prev_cke = 1, prev_req = 0, done = 0;

    function automatic int xsr_len();
        return (TXSR < 2) ? 2 : TXSR;
    endfunction
    function automatic int gap_limit();
        return INTERVAL + 4;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        clk = 0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    // Grant model: random 0..3 cycle latency, held while busy.
    initial begin
        int dly = 0;
        ref_grant = 0;
        forever begin
            @(negedge clk);
            if (busy) ref_grant = 1;
            else if (ref_req && grant_en) begin
                if (dly == 0) ref_grant = 1;
                else begin ref_grant = 0; dly--; end
            end else begin
                ref_grant = 0;
                dly = $urandom % 4;
            end
        end
    end

    // Pin monitor, sampled just after each rising edge.
    always @(posedge clk) begin
        logic [3:0] c;
        #1;
        cyc++;
        c = {cs_n, ras_n, cas_n, we_n};
        if (rst_n && !done) begin
            if (c != NOP) chk(ref_grant, "R5", "command without grant", c, NOP);
            if (c == PALL) begin
                chk(a10 == 1, "R3", "precharge A10", a10, 1);
                t_pall = cyc;
            end
            if (c == REF && cke) begin
                chk(cyc - t_pall == TRP, "R3", "precharge-to-refresh", cyc - t_pall, TRP);
                chk(busy == 1, "R4", "busy on refresh", busy, 1);
                if (gap_en && last_ref >= 0)
                    chk(cyc - last_ref <= gap_limit(), "R2", "refresh gap", cyc - last_ref, gap_limit());
                last_ref = cyc; t_ref = cyc; n_ref++;
            end
            if (t_ref >= 0 && cyc > t_ref && cyc < t_ref + TRC)
                chk(c == NOP && busy, "R4", "NOP+busy during tRC", {busy, c}, {1'b1, NOP});
            if (t_ref >= 0 && cyc == t_ref + TRC)
                chk(!busy, "R4", "busy after tRC", busy, 0);
            if (!cke && prev_cke) begin
                chk(c == REF, "R7", "entry encoding", c, REF);
                chk(cyc - t_pall == TRP, "R7", "precharge-to-entry", cyc - t_pall, TRP);
                t_sre = cyc;
            end
            if (cke && !prev_cke) begin
                chk(cyc - t_sre >= TRAS + 1, "R8", "self-refresh stay", cyc - t_sre, TRAS + 1);
                chk(clk_stable && !sr_req, "R9", "exit gate", {clk_stable, sr_req}, 2);
                t_x = cyc; last_ref = -1;
            end
            if (t_x >= 0 && cyc >= t_x && cyc < t_x + xsr_len())
                chk(c == NOP && busy, "R10", "exit NOP window", {busy, c}, {1'b1, NOP});
            if (t_x >= 0 && cyc == t_x + xsr_len()) begin
                chk(!busy, "R10", "busy after exit window", busy, 0);
                t_idle = cyc;
            end
            if (t_idle >= 0 && ref_req && !prev_req) begin
                chk(cyc - t_idle == INTERVAL + 1, "R11", "first request after exit",
                    cyc - t_idle, INTERVAL + 1);
                t_idle = -1;
            end
        end
        prev_cke = cke;
        prev_req = ref_req;
    end

    task automatic wait_cke(input bit v);
        int n = 0;
        while (cke != v && n < 2000) begin @(negedge clk); n++; end
        if (cke != v) chk(0, "R9", "timeout waiting for cke", cke, v);
    endtask

    task automatic wait_req();
        int n = 0;
        while (!ref_req && n < 4 * INTERVAL) begin @(negedge clk); n++; end
        if (!ref_req) chk(0, "R11", "timeout waiting for request", 0, 1);
    endtask

    task automatic wait_quiet();
        int q = 0, n = 0;
        while (q < 4 && n < 4000) begin
            @(negedge clk); n++;
            if (!ref_req && !busy) q++; else q = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; sr_req = 0; clk_stable = 1;
        repeat (3) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "reset command", {cs_n, ras_n, cas_n, we_n}, NOP);
        chk(cke == 1, "R1", "reset cke", cke, 1);
        chk(!ref_req && !busy && !urgent, "R1", "reset flags", {ref_req, busy, urgent}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == NOP && !ref_req && !busy, "R1", "first cycle out of reset",
            {ref_req, busy}, 0);

        // Backlog without grants (R6, R5).
        repeat (INTERVAL * 15 / 2) @(negedge clk);
        chk(urgent == 0, "R6", "urgent at 7 missed", urgent, 0);
        chk(ref_req == 1, "R5", "request held without grant", ref_req, 1);
        chk({cs_n, ras_n, cas_n, we_n} == NOP, "R5", "bus idle without grant", {cs_n, ras_n, cas_n, we_n}, NOP);
        repeat (INTERVAL) @(negedge clk);
        chk(urgent == 1, "R6", "urgent at 8 missed", urgent, 1);
        n_ref = 0;
        grant_en = 1;
        wait_quiet();
        chk(n_ref >= URG, "R6", "backlog drained", n_ref, URG);
        chk(urgent == 0, "R6", "urgent cleared", urgent, 0);

        // Steady pacing with random grant latency (R2, R3, R4).
        last_ref = -1; gap_en = 1;
        repeat (INTERVAL * 5) @(negedge clk);

        // Early exit request: residence floor (R8).
        wait_quiet();
        sr_req = 1;
        wait_cke(0);
        sr_req = 0;
        wait_cke(1);
        chk(t_x - t_sre == TRAS + 1, "R8", "early exit held to floor", t_x - t_sre, TRAS + 1);
        wait_req();

        // Unstable clock keeps the device parked (R9).
        wait_quiet();
        clk_stable = 0; sr_req = 1;
        wait_cke(0);
        sr_req = 0;
        repeat (TRAS + 20) @(negedge clk);
        chk(cke == 0, "R9", "cke low while clock unstable", cke, 0);
        clk_stable = 1;
        wait_cke(1);
        wait_req();

        // Random self-refresh stays (R7-R11).
        for (int k = 0; k < 4; k++) begin
            repeat ($urandom % 20) @(negedge clk);
            sr_req = 1;
            wait_cke(0);
            repeat (TRAS / 2 + ($urandom % 40)) @(negedge clk);
            sr_req = 0;
            wait_cke(1);
            wait_req();
        end
        wait_quiet();
        finish_run();
    end
endmodule